// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block runs ahead of an instruction consumer and keeps up to six instruction bytes ready for it. A fetch pointer, made of a 16-bit segment and a 16-bit offset, gives the next code location. The block turns that pointer into a 20-bit physical address and issues one fetch at a time to a bus sequencer. A fetch is a 16-bit word when the offset is even and a single byte when the offset is odd. The bytes returned enter a small first-in first-out store. The consumer takes bytes one at a time from the head of that store.

The execution side can also ask for the bus to make a data transfer. The block grants that request at once when no fetch is pending. When a fetch is under way, the grant waits until the fetch completes. The fetch is never cut short. When the consumer takes a jump, call or return, it drives a redirect with a new segment and offset. The block then empties the store, drops any response still on its way for the old stream, and restarts fetching at the new address.

Top module: `pfq_ctrl`

## Requirements
- R1: After reset the store is empty (`pop_valid` low), the segment is 0xFFFF and the offset is 0, so the first request is a word fetch at physical address 0xFFFF0.
- R2: Each fetch address equals (segment × 16 + offset) modulo 2^20. The offset wraps modulo 2^16 and the segment does not change when the offset advances.
- R3: With an even offset, the block issues a word fetch (`fch_single` = 0). `fch_data[7:0]` is the byte at the address and `fch_data[15:8]` is the byte after it, and the offset advances by 2. With an odd offset, it issues a byte fetch (`fch_single` = 1). The byte comes on `fch_data[15:8]` and the offset advances by 1.
- R4: `pop_byte` is the oldest stored byte, and bytes come out in increasing address order. `pop_valid` is low while the store is empty, and `pop_take` has no effect then.
- R5: A new fetch starts only while at least two of the six byte slots are free. Left alone, a stream started at an even offset therefore fills all 6 slots. One started at an odd offset stops at 5 bytes.
- R6: A cycle with `redir` high leaves the store empty on the next cycle. The next fetch uses the new segment and offset. No fetch starts in the redirect cycle itself.
- R7: A response to a fetch that was outstanding at a redirect, or that arrives in the same cycle as a redirect, is discarded and never reaches the store.
- R8: When `dacc_req` is raised while no fetch is pending, `dacc_gnt` rises one cycle later. It stays high until `dacc_done`, and no fetch is issued while it is high. A redirect during the grant does not remove the grant.
- R9: While a fetch is pending, `dacc_gnt` stays low. It rises on the cycle after the fetch is acknowledged. A pending data request wins over starting another fetch.
- R10: `fch_req`, `fch_addr` and `fch_single` stay constant from the cycle a request is raised until the cycle of its `fch_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fch_req | output | 1 | Fetch request to the bus sequencer |
| fch_addr | output | 20 | Physical fetch address |
| fch_single | output | 1 | 1 = byte fetch (odd offset), 0 = word fetch |
| fch_ack | input | 1 | Fetch completes this cycle; data valid |
| fch_data | input | 16 | Fetched data, low byte at the even address |
| pop_valid | output | 1 | Head byte present |
| pop_byte | output | 8 | Head byte |
| pop_take | input | 1 | Remove the head byte |
| redir | input | 1 | Flush and restart at a new address |
| redir_seg | input | 16 | New segment value |
| redir_ofs | input | 16 | New offset value |
| dacc_req | input | 1 | Execution side asks for the bus |
| dacc_gnt | output | 1 | Bus granted to the execution side |
| dacc_done | input | 1 | Execution side releases the bus |

## Verification
Two kinds of event can land on the same clock edge. One is a redirect together with a fetch still in flight. The other is a data request together with a fetch about to be acknowledged. The bench provokes the first by holding its bus model's acknowledge while it redirects. It then releases the acknowledge and judges two things: that the store is still empty just after the stale response, and that every later byte follows the new address. It provokes the second by raising the data request during a held fetch. It then checks that the grant stays low until the acknowledge, rises on the very next cycle, and holds with no fetch issued while the consumer frees room.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int SEG_W  = 16;
    localparam int OFS_W  = 16;
    localparam int PHY_W  = SEG_W + 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [SEG_W-1:0] SEG_AT_RESET = '1;
    localparam logic [OFS_W-1:0] OFS_AT_RESET = '0;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_DATA  = 2'd2
    } sq_state_e;

    // A fetch issued toward the bus sequencer
    typedef struct packed {
        logic [PHY_W-1:0] addr;
        logic             single;
    } fetch_cmd_t;

    // Bytes written into the store in one cycle (n = 0, 1 or 2)
    typedef struct packed {
        logic [1:0]        n;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } fill_t;

    function automatic logic [PHY_W-1:0] phys_of(input logic [SEG_W-1:0] seg,
                                                 input logic [OFS_W-1:0] ofs);
        return {seg, 4'b0000} + {4'b0000, ofs};
    endfunction
endpackage

// File: rtl/pfq_store.sv
module pfq_store
    import pfq_pkg::*;
#(
    parameter int  DEPTH = 6,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              pop,
    input  fill_t             fill,
    output logic [BYTE_W-1:0] head,
    output logic [CW-1:0]     count
);
    logic [DEPTH-1:0][BYTE_W-1:0] slot_q;
    logic [DEPTH-1:0][BYTE_W-1:0] slot_d;
    logic                         do_pop;
    logic [CW-1:0]                base;
    logic [CW-1:0]                count_d;

    assign do_pop  = pop && (count != '0);
    assign base    = count - CW'(do_pop);
    assign count_d = clr ? '0 : (base + CW'(fill.n));

    // Each slot either shifts toward the head or takes a new byte
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam int NXT = (g < DEPTH - 1) ? g + 1 : g;
        logic [BYTE_W-1:0] shifted;

        assign shifted = do_pop ? slot_q[NXT] : slot_q[g];

        always_comb begin
            if (fill.n != 2'd0 && base == CW'(g))
                slot_d[g] = fill.b0;
            else if (fill.n == 2'd2 && (base + CW'(1)) == CW'(g))
                slot_d[g] = fill.b1;
            else
                slot_d[g] = shifted;
        end

        always_ff @(posedge clk) begin
            if (rst) slot_q[g] <= '0;
            else     slot_q[g] <= slot_d[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_d;
    end

    assign head = slot_q[0];
endmodule

// File: rtl/pfq_addr.sv
module pfq_addr
    import pfq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             redir,
    input  logic [SEG_W-1:0] redir_seg,
    input  logic [OFS_W-1:0] redir_ofs,
    input  logic             adv,
    input  logic             adv_one,
    output logic [PHY_W-1:0] phys,
    output logic             odd
);
    logic [SEG_W-1:0] seg_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SEG_AT_RESET;
            ofs_q <= OFS_AT_RESET;
        end else if (redir) begin
            seg_q <= redir_seg;
            ofs_q <= redir_ofs;
        end else if (adv) begin
            ofs_q <= ofs_q + (adv_one ? OFS_W'(1) : OFS_W'(2));
        end
    end

    assign phys = phys_of(seg_q, ofs_q);
    assign odd  = ofs_q[0];
endmodule

// File: rtl/pfq_seq.sv
module pfq_seq
    import pfq_pkg::*;
#(
    parameter int  DEPTH    = 6,
    parameter int  MIN_FREE = 2,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    count,
    input  logic             redir,
    input  logic             fch_ack,
    input  logic             dacc_req,
    input  logic             dacc_done,
    input  logic [PHY_W-1:0] cur_phys,
    input  logic             cur_odd,
    output sq_state_e        state,
    output fetch_cmd_t       cmd,
    output logic             accept
);
    localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - MIN_FREE);

    sq_state_e state_d;
    logic      room;
    logic      stale_q;

    assign room = (count <= ROOM_MAX);

    always_comb begin
        state_d = state;
        unique case (state)
            SQ_IDLE: begin
                if (dacc_req)            state_d = SQ_DATA;
                else if (room && !redir) state_d = SQ_FETCH;
            end
            SQ_FETCH: begin
                if (fch_ack) state_d = dacc_req ? SQ_DATA : SQ_IDLE;
            end
            SQ_DATA: begin
                if (dacc_done) state_d = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cmd     <= '0;
            stale_q <= 1'b0;
        end else begin
            state <= state_d;
            if (state == SQ_IDLE && state_d == SQ_FETCH) begin
                cmd.addr   <= cur_phys;
                cmd.single <= cur_odd;
            end
            if (state == SQ_FETCH && fch_ack)
                stale_q <= 1'b0;
            else if (state == SQ_FETCH && redir)
                stale_q <= 1'b1;
        end
    end

    assign accept = (state == SQ_FETCH) && fch_ack && !stale_q && !redir;
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
    import pfq_pkg::*;
#(
    parameter int  DEPTH    = 6,
    parameter int  MIN_FREE = 2,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              fch_req,
    output logic [PHY_W-1:0]  fch_addr,
    output logic              fch_single,
    input  logic              fch_ack,
    input  logic [WORD_W-1:0] fch_data,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_byte,
    input  logic              pop_take,
    input  logic              redir,
    input  logic [SEG_W-1:0]  redir_seg,
    input  logic [OFS_W-1:0]  redir_ofs,
    input  logic              dacc_req,
    output logic              dacc_gnt,
    input  logic              dacc_done
);
    sq_state_e        state;
    fetch_cmd_t       cmd;
    logic             accept;
    logic [CW-1:0]    q_count;
    logic [PHY_W-1:0] cur_phys;
    logic             cur_odd;
    fill_t            fill;

    pfq_addr u_addr (
        .clk       (clk),
        .rst       (rst),
        .redir     (redir),
        .redir_seg (redir_seg),
        .redir_ofs (redir_ofs),
        .adv       (accept),
        .adv_one   (cmd.single),
        .phys      (cur_phys),
        .odd       (cur_odd)
    );

    pfq_seq #(.DEPTH(DEPTH), .MIN_FREE(MIN_FREE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .count     (q_count),
        .redir     (redir),
        .fch_ack   (fch_ack),
        .dacc_req  (dacc_req),
        .dacc_done (dacc_done),
        .cur_phys  (cur_phys),
        .cur_odd   (cur_odd),
        .state     (state),
        .cmd       (cmd),
        .accept    (accept)
    );

    // Odd-address byte arrives on the upper lane
    always_comb begin
        fill.n  = accept ? (cmd.single ? 2'd1 : 2'd2) : 2'd0;
        fill.b0 = cmd.single ? fch_data[WORD_W-1:BYTE_W] : fch_data[BYTE_W-1:0];
        fill.b1 = fch_data[WORD_W-1:BYTE_W];
    end

    pfq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (redir),
        .pop   (pop_take),
        .fill  (fill),
        .head  (pop_byte),
        .count (q_count)
    );

    assign pop_valid  = (q_count != '0);
    assign fch_req    = (state == SQ_FETCH);
    assign fch_addr   = cmd.addr;
    assign fch_single = cmd.single;
    assign dacc_gnt   = (state == SQ_DATA);
endmodule

// File: rtl/pfq_checks.sv
module pfq_checks
    import pfq_pkg::*;
#(
    parameter int  DEPTH    = 6,
    parameter int  MIN_FREE = 2,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fch_req,
    input logic [PHY_W-1:0] fch_addr,
    input logic             fch_single,
    input logic             fch_ack,
    input logic             pop_valid,
    input logic             redir,
    input logic             dacc_gnt,
    input logic [CW-1:0]    q_count
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pop_valid);

    // R3
    width_by_parity_chk: assert property (@(posedge clk) disable iff (rst)
        fch_req |-> (fch_single == fch_addr[0]));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(DEPTH));

    // R5
    room_at_issue_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fch_req) |-> (q_count <= CW'(DEPTH - MIN_FREE)));

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        redir |=> !pop_valid);

    // R8
    no_fetch_in_grant_chk: assert property (@(posedge clk) disable iff (rst)
        dacc_gnt |-> !fch_req);

    // R9
    grant_waits_chk: assert property (@(posedge clk) disable iff (rst)
        (fch_req && !fch_ack) |=> !dacc_gnt);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fch_req && !fch_ack) |=> (fch_req && $stable(fch_addr) && $stable(fch_single)));
endmodule

bind pfq_ctrl pfq_checks #(.DEPTH(DEPTH), .MIN_FREE(MIN_FREE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fch_req    (fch_req),
    .fch_addr   (fch_addr),
    .fch_single (fch_single),
    .fch_ack    (fch_ack),
    .pop_valid  (pop_valid),
    .redir      (redir),
    .dacc_gnt   (dacc_gnt),
    .q_count    (q_count)
);

// File: tb/sim_pfq_ctrl.sv
module sim_pfq_ctrl;
    import pfq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fch_req, fch_single, fch_ack = 1'b0;
    logic [19:0] fch_addr;
    logic [15:0] fch_data = '0;
    logic        pop_valid, pop_take = 1'b0;
    logic [7:0]  pop_byte;
    logic        redir = 1'b0;
    logic [15:0] redir_seg = '0, redir_ofs = '0;
    logic        dacc_req = 1'b0, dacc_gnt, dacc_done = 1'b0;

    always #10 clk = ~clk;

    pfq_ctrl #(.DEPTH(6), .MIN_FREE(2)) u0 (
        .clk(clk), .rst(rst),
        .fch_req(fch_req), .fch_addr(fch_addr), .fch_single(fch_single),
        .fch_ack(fch_ack), .fch_data(fch_data),
        .pop_valid(pop_valid), .pop_byte(pop_byte), .pop_take(pop_take),
        .redir(redir), .redir_seg(redir_seg), .redir_ofs(redir_ofs),
        .dacc_req(dacc_req), .dacc_gnt(dacc_gnt), .dacc_done(dacc_done)
    );

    int n_chk = 0, n_err = 0;
    int pops = 0, nreq = 0, wait_cnt = 0;
    bit hold = 0, cons_en = 0, stale = 0, inflight = 0, done = 0;
    logic [15:0] f_seg = 16'hFFFF, f_ofs = 16'h0000;  // fetch model
    logic [15:0] c_seg = 16'hFFFF, c_ofs = 16'h0000;  // consumer model

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem(input logic [19:0] a);
        return 8'(a * 20'd13 + (a >> 8) + 20'd7);
    endfunction

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return 20'({s, 4'b0000} + {4'b0000, o});
    endfunction

    // Bus sequencer model and consumer, acting on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (fch_ack) begin
                    fch_ack = 1'b0;
                end else if (fch_req) begin
                    if (!inflight) begin
                        inflight = 1;
                        nreq++;
                        wait_cnt = nreq % 3;
                        if (!stale) begin
                            check(fch_addr == pa(f_seg, f_ofs), "R2", "fetch address",
                                  fch_addr, pa(f_seg, f_ofs));
                            check(fch_single == f_ofs[0], "R3", "fetch width",
                                  fch_single, f_ofs[0]);
                        end
                    end
                    if (!hold) begin
                        if (wait_cnt == 0) begin
                            fch_ack  = 1'b1;
                            fch_data = fch_single ? {mem(fch_addr), 8'hEE}
                                                  : {mem(fch_addr + 20'd1), mem(fch_addr)};
                            inflight = 0;
                            if (stale) stale = 0;
                            else       f_ofs = f_ofs + (fch_single ? 16'd1 : 16'd2);
                        end else begin
                            wait_cnt--;
                        end
                    end
                end
                if (cons_en && pop_valid) begin
                    pop_take = 1'b1;
                    check(pop_byte == mem(pa(c_seg, c_ofs)), "R4", "popped byte",
                          pop_byte, mem(pa(c_seg, c_ofs)));
                    c_ofs = c_ofs + 16'd1;
                    pops++;
                end else begin
                    pop_take = 1'b0;
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic redirect(input logic [15:0] s, input logic [15:0] o, input bit cons_after);
        cons_en   = 0;
        stale     = stale || (fch_req && !fch_ack);
        redir     = 1'b1;
        redir_seg = s;
        redir_ofs = o;
        f_seg = s; f_ofs = o;
        c_seg = s; c_ofs = o;
        step();
        redir = 1'b0;
        // R6: flushed store is empty
        check(!pop_valid, "R6", "store empty after redirect", pop_valid, 0);
        cons_en = cons_after;
    endtask

    task automatic wait_for_req();
        for (int i = 0; i < 50 && !fch_req; i++) step();
        check(fch_req, "R5", "fetch request appears", fch_req, 1);
    endtask

    task automatic count_held(input int exp_n, input string what);
        int p0;
        hold = 1;
        p0 = pops;
        cons_en = 1;
        repeat (14) step();
        cons_en = 0;
        // R5: contents of a settled store
        check(pops - p0 == exp_n, "R5", what, pops - p0, exp_n);
        hold = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        logic [19:0] held_addr;
        repeat (3) step();
        rst = 1'b0;
        // R1: empty after reset
        check(!pop_valid, "R1", "pop_valid after reset", pop_valid, 0);
        step();
        check(fch_req && fch_addr == 20'hFFFF0 && !fch_single, "R1", "first fetch address",
              fch_addr, 20'hFFFF0);

        // R4: continuous stream from reset address
        cons_en = 1;
        for (int i = 0; i < 400 && pops < 40; i++) step();
        check(pops >= 40, "R4", "stream progress", pops, 40);

        // R5: even start fills six slots
        redirect(16'h1234, 16'h0100, 0);
        repeat (30) step();
        check(!fch_req, "R5", "no fetch with full store", fch_req, 0);
        count_held(6, "bytes held from even start");

        // R3 R5: odd start stops at five bytes
        redirect(16'h2001, 16'h0201, 0);
        repeat (30) step();
        check(!fch_req, "R5", "no fetch with one free slot", fch_req, 0);
        count_held(5, "bytes held from odd start");

        // R7: redirect while a fetch is outstanding
        cons_en = 1;
        repeat (4) step();
        hold = 1;
        wait_for_req();
        redirect(16'h0800, 16'h0010, 1);
        hold = 0;
        for (int i = 0; i < 10 && !fch_ack; i++) step();
        check(!pop_valid, "R7", "stale response not stored", pop_valid, 0);
        begin
            int p0 = pops;
            for (int i = 0; i < 200 && pops - p0 < 12; i++) step();
            check(pops - p0 >= 12, "R7", "new stream after stale drop", pops - p0, 12);
        end

        // R9 R10: data request during a held fetch
        hold = 1;
        wait_for_req();
        held_addr = fch_addr;
        dacc_req = 1'b1;
        repeat (4) begin
            step();
            check(!dacc_gnt, "R9", "no grant during fetch", dacc_gnt, 0);
        end
        check(fch_req && fch_addr == held_addr, "R10", "request held stable", fch_addr, held_addr);
        hold = 0;
        for (int i = 0; i < 10 && !fch_ack; i++) step();
        check(dacc_gnt, "R9", "grant after fetch ack", dacc_gnt, 1);
        check(!fch_req, "R9", "data wins over next fetch", fch_req, 0);

        // R8: grant holds, no fetch while consumer drains
        repeat (10) begin
            step();
            check(dacc_gnt && !fch_req, "R8", "grant held without fetch", {dacc_gnt, fch_req}, 2);
        end
        dacc_done = 1'b1;
        dacc_req  = 1'b0;
        step();
        dacc_done = 1'b0;
        check(!dacc_gnt, "R8", "grant released", dacc_gnt, 0);

        // R8: request while idle with a full store
        cons_en = 0;
        repeat (30) step();
        dacc_req = 1'b1;
        step();
        check(dacc_gnt, "R8", "grant one cycle after idle request", dacc_gnt, 1);
        redirect(16'h0300, 16'h0040, 0);
        check(dacc_gnt, "R8", "grant survives redirect", dacc_gnt, 1);
        dacc_done = 1'b1;
        dacc_req  = 1'b0;
        step();
        dacc_done = 1'b0;

        // R2: physical address wraps at 20 bits, offset wraps at 16 bits
        redirect(16'hFFFF, 16'hFFFC, 1);
        begin
            int p0 = pops;
            for (int i = 0; i < 300 && pops - p0 < 24; i++) step();
            check(pops - p0 >= 24, "R2", "stream across wrap", pops - p0, 24);
        end

        // R4: take with an empty store has no effect
        cons_en = 0;
        redirect(16'h0100, 16'h0000, 0);
        hold = 1;
        pop_take = 1'b1;
        step();
        check(!pop_valid, "R4", "empty store stays empty", pop_valid, 0);
        pop_take = 1'b0;
        hold = 0;
        cons_en = 1;
        begin
            int p0 = pops;
            for (int i = 0; i < 200 && pops - p0 < 8; i++) step();
            check(pops - p0 >= 8, "R4", "stream after empty take", pops - p0, 8);
        end

        done = 1;
        finish_run();
    end
endmodule